// File: doc/BRIEF.md
# Integer ALU with Flag Update

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes a 4-bit operation code, the first operand, and the already-shifted second operand. It produces the operation result, a destination write enable and the next values of the four condition flags: negative, zero, carry and overflow. The register file, the barrel shifter and pipeline control sit outside the block. The shifter's carry-out and the current flags come in as plain inputs.

The outputs are registered, so a result appears one clock after its inputs are presented. The block has three flag behaviours:

- Logical operations pass the shifter's carry through to the carry flag.
- Subtract-type operations report carry as "no borrow".
- A flag-setting operation that targets the program counter, in a mode that keeps a saved status, selects the saved flags and raises a restore request instead of computing new flags.

Top module: `alu_flag_unit`

## Requirements
- R1: Logical results use the opcode encoding as follows: 0000 a AND b, 0001 a XOR b, 1000 a AND b, 1001 a XOR b, 1100 a OR b, 1101 b, 1110 a AND NOT b, 1111 NOT b. Here a is the first operand and b is the second operand.
- R2: Arithmetic results use the opcode encoding as follows, where C is flag bit 1 (flag vector order is N, Z, C, V from bit 3 down to bit 0):
  - 0010 a-b
  - 0011 b-a
  - 0100 a+b
  - 0101 a+b+C
  - 0110 a-b-(1-C)
  - 0111 b-a-(1-C)
  - 1010 a-b
  - 1011 a+b
- R3: For add-type operations (0100, 0101, 1011) with flags updated, N is result bit 31, Z is set when the result is zero, C is the unsigned carry out of bit 31, and V is signed overflow.
- R4: For subtract-type operations (0010, 0011, 0110, 0111, 1010) with flags updated, N and Z follow the result, C is 1 exactly when no borrow occurs, and V is signed overflow of the subtraction.
- R5: For logical operations with flags updated, N and Z follow the result, C equals the shifter carry input, and V keeps its current value.
- R6: Operations 1000 to 1011 never assert the write enable. Their result output still carries the computed value, and their flags follow R3 to R5 whenever the flags are updated.
- R7: When the set-flags input is low, the flag output equals the current flags input and the restore request is low.
- R8: When set-flags, destination-is-PC and has-saved-status are all high, the flag output equals the saved flags input and the restore request is high. The result and write enable are unaffected.
- R9: Operations outside 1000 to 1011 always assert the write enable.
- R10: While reset is low at a clock edge, all outputs are cleared to zero.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request flag update |
| operand_a_i | input | 32 | First operand |
| operand_b_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Carry out of the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| dst_is_pc_i | input | 1 | Destination is the program counter |
| has_saved_i | input | 1 | Current mode holds a saved status |
| saved_flags_i | input | 4 | Saved status flags {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| restore_o | output | 1 | Request to copy saved status into current status |

## Verification
Two functions can fall in the same cycle:

- the status restore;
- the destination write, or a compare's computed result.

This happens when a flag-setting operation targets the program counter in a mode with a saved status. The bench provokes it by sweeping all sixteen opcodes through every combination of set-flags, destination-is-PC and has-saved-status, with distinct current and saved flags. Each output is judged separately: the result and write enable must match the arithmetic model, while the flags must equal the saved value and the restore request must be high.

// File: rtl/alu_flag_pkg.sv
// Package: shared types for the integer ALU.
// Assumes flags are packed N,Z,C,V from MSB to LSB.
package alu_flag_pkg;

    localparam int unsigned OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     arith;      // adder path, else logic path
        logic     swap;       // exchange operands before the adder
        logic     inv_second; // invert adder second input (subtract)
        cin_sel_e cin;        // adder carry-in source
        logic     writes;     // destination written
    } op_ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Turns the 4-bit operation code into adder/logic path controls.
// Assumes: purely combinational, every code is defined.
module alu_op_decode
    import alu_flag_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    output op_ctrl_t         ctrl_o
);

    // Decode each operation into its datapath controls.
    always_comb begin
        ctrl_o = '{arith: 1'b0, swap: 1'b0, inv_second: 1'b0,
                   cin: CIN_ZERO, writes: 1'b1};
        unique case (alu_op_e'(op_i))
            OP_SUB, OP_CMP: begin
                ctrl_o.arith      = 1'b1;
                ctrl_o.inv_second = 1'b1;
                ctrl_o.cin        = CIN_ONE;
            end
            OP_RSB: begin
                ctrl_o.arith      = 1'b1;
                ctrl_o.swap       = 1'b1;
                ctrl_o.inv_second = 1'b1;
                ctrl_o.cin        = CIN_ONE;
            end
            OP_ADD, OP_CMN: ctrl_o.arith = 1'b1;
            OP_ADC: begin
                ctrl_o.arith = 1'b1;
                ctrl_o.cin   = CIN_FLAG;
            end
            OP_SBC: begin
                ctrl_o.arith      = 1'b1;
                ctrl_o.inv_second = 1'b1;
                ctrl_o.cin        = CIN_FLAG;
            end
            OP_RSC: begin
                ctrl_o.arith      = 1'b1;
                ctrl_o.swap       = 1'b1;
                ctrl_o.inv_second = 1'b1;
                ctrl_o.cin        = CIN_FLAG;
            end
            default: ;
        endcase
        if (op_i[3:2] == 2'b10) begin
            ctrl_o.writes = 1'b0;
        end
    end

endmodule

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// One adder serving all add and subtract forms: x + (inv ? ~y : y) + cin.
// Assumes: subtract is done as add of the inverse, so carry-out is
// directly the "no borrow" indication.
module alu_addsub
    import alu_flag_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             swap_i,
    input  logic             inv_i,
    input  cin_sel_e         cin_sel_i,
    input  logic             carry_flag_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y;
    logic             cin;
    logic [WIDTH:0]   full;

    // Select operand order, inversion and carry-in.
    always_comb begin
        x = swap_i ? b_i : a_i;
        y = swap_i ? a_i : b_i;
        if (inv_i) begin
            y = ~y;
        end
        unique case (cin_sel_i)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = carry_flag_i;
            default:  cin = 1'b0;
        endcase
    end

    // Wide add, carry out and signed overflow.
    always_comb begin
        full   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise path for the logical, test and move operations.
// Assumes: arithmetic codes are don't-care here (output zero).
module alu_logic
    import alu_flag_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [OPC_W-1:0] op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    // Pick the bitwise function for the opcode.
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: alu_flag_unit (top)
// Executes one data-processing operation per cycle and registers the
// result, write enable, next flags and the saved-status restore request.
// Assumes: operand_b_i is already shifted; flags packed {N,Z,C,V}.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic             set_flags_i,
    input  logic [WIDTH-1:0] operand_a_i,
    input  logic [WIDTH-1:0] operand_b_i,
    input  logic             shift_carry_i,
    input  logic [3:0]       flags_i,
    input  logic             dst_is_pc_i,
    input  logic             has_saved_i,
    input  logic [3:0]       saved_flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [3:0]       flags_o,
    output logic             restore_o
);

    localparam int unsigned MSB = WIDTH - 1;

    op_ctrl_t         ctrl;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ovf;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] res_d;
    flags_t           cur;
    flags_t           flags_d;
    logic             restore_d;

    assign cur = flags_t'(flags_i);

    alu_op_decode u_dec (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a_i          (operand_a_i),
        .b_i          (operand_b_i),
        .swap_i       (ctrl.swap),
        .inv_i        (ctrl.inv_second),
        .cin_sel_i    (ctrl.cin),
        .carry_flag_i (cur.c),
        .sum_o        (sum),
        .cout_o       (cout),
        .ovf_o        (ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_log (
        .op_i  (op_i),
        .a_i   (operand_a_i),
        .b_i   (operand_b_i),
        .res_o (logic_res)
    );

    // Choose the result path and form next flags or a restore.
    always_comb begin
        res_d     = ctrl.arith ? sum : logic_res;
        restore_d = 1'b0;
        flags_d   = cur;
        if (set_flags_i) begin
            if (dst_is_pc_i && has_saved_i) begin
                restore_d = 1'b1;
                flags_d   = flags_t'(saved_flags_i);
            end else begin
                flags_d.n = res_d[MSB];
                flags_d.z = (res_d == '0);
                flags_d.c = ctrl.arith ? cout : shift_carry_i;
                flags_d.v = ctrl.arith ? ovf : cur.v;
            end
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            flags_o   <= '0;
            restore_o <= 1'b0;
        end else begin
            result_o  <= res_d;
            wr_en_o   <= ctrl.writes;
            flags_o   <= flags_d;
            restore_o <= restore_d;
        end
    end

    logic is_logic_op;
    logic take_restore;
    assign is_logic_op  = (op_i inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});
    assign take_restore = set_flags_i && dst_is_pc_i && has_saved_i;

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] == 2'b10) |=> !wr_en_o);

    // R9
    op_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] != 2'b10) |=> wr_en_o);

    // R7
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> (flags_o == $past(flags_i)) && !restore_o);

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_restore |=> restore_o && (flags_o == $past(saved_flags_i)));

    // R5
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && !take_restore && is_logic_op)
        |=> (flags_o[1] == $past(shift_carry_i)) && (flags_o[0] == $past(flags_i[0])));

    // R3 R4 R5: N and Z agree with the registered result
    nz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && !take_restore)
        |=> (flags_o[3] == result_o[MSB]) && (flags_o[2] == (result_o == '0)));

endmodule

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_i;
    logic        set_flags_i;
    logic [31:0] operand_a_i;
    logic [31:0] operand_b_i;
    logic        shift_carry_i;
    logic [3:0]  flags_i;
    logic        dst_is_pc_i;
    logic        has_saved_i;
    logic [3:0]  saved_flags_i;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;
    logic        restore_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_unit i_alu_flag_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_i          (op_i),
        .set_flags_i   (set_flags_i),
        .operand_a_i   (operand_a_i),
        .operand_b_i   (operand_b_i),
        .shift_carry_i (shift_carry_i),
        .flags_i       (flags_i),
        .dst_is_pc_i   (dst_is_pc_i),
        .has_saved_i   (has_saved_i),
        .saved_flags_i (saved_flags_i),
        .result_o      (result_o),
        .wr_en_o       (wr_en_o),
        .flags_o       (flags_o),
        .restore_o     (restore_o)
    );

    function automatic logic [31:0] pick(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hFFFF_0000;
            default: return 32'h0000_8000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic s, input logic [3:0] fl, input logic sc,
                           input logic pc, input logic hs, input logic [3:0] sv);
        logic [31:0] m, n, er;
        logic [63:0] ut;
        longint      st;
        logic        k, is_sub, arith, ewe, ers;
        logic [3:0]  ef;
        string       rtag, ftag, wtag;
        @(negedge clk);
        op_i = op; operand_a_i = a; operand_b_i = b; set_flags_i = s;
        flags_i = fl; shift_carry_i = sc; dst_is_pc_i = pc; has_saved_i = hs;
        saved_flags_i = sv;
        arith = 1'b1; is_sub = 1'b0; m = a; n = b; k = 1'b0; er = '0;
        case (op)
            4'h2, 4'hA: begin is_sub = 1'b1; k = 1'b0; end
            4'h3:       begin is_sub = 1'b1; m = b; n = a; end
            4'h4, 4'hB: k = 1'b0;
            4'h5:       k = fl[1];
            4'h6:       begin is_sub = 1'b1; k = ~fl[1]; end
            4'h7:       begin is_sub = 1'b1; m = b; n = a; k = ~fl[1]; end
            default:    arith = 1'b0;
        endcase
        ef = fl;
        if (arith) begin
            if (is_sub) begin
                er = m - n - {31'b0, k};
                ef[1] = (64'(m) >= 64'(n) + 64'(k));
                st = longint'($signed(m)) - longint'($signed(n)) - longint'(k);
            end else begin
                ut = 64'(m) + 64'(n) + 64'(k);
                er = ut[31:0];
                ef[1] = ut[32];
                st = longint'($signed(m)) + longint'($signed(n)) + longint'(k);
            end
            ef[0] = (st > 64'sd2147483647) || (st < -64'sd2147483648);
        end else begin
            case (op)
                4'h0, 4'h8: er = a & b;
                4'h1, 4'h9: er = a ^ b;
                4'hC:       er = a | b;
                4'hD:       er = b;
                4'hE:       er = a & ~b;
                default:    er = ~b;
            endcase
            ef[1] = sc;
        end
        ef[3] = er[31];
        ef[2] = (er == 32'h0);
        ewe  = (op[3:2] != 2'b10);
        ers  = s && pc && hs;
        if (!s)      ef = fl;
        else if (ers) ef = sv;
        rtag = arith ? "R2" : "R1";
        wtag = ewe ? "R9" : "R6";
        if (!s)            ftag = "R7";
        else if (ers)      ftag = "R8";
        else if (!arith)   ftag = "R5";
        else if (is_sub)   ftag = "R4";
        else               ftag = "R3";
        @(posedge clk);
        #1;
        chk(rtag, result_o, er);
        chk(wtag, {31'b0, wr_en_o}, {31'b0, ewe});
        chk(ftag, {28'b0, flags_o}, {28'b0, ef});
        chk(s ? "R8" : "R7", {31'b0, restore_o}, {31'b0, ers});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R11: watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_i = 4'h4; set_flags_i = 1'b1; operand_a_i = 32'hFFFF_FFFF;
        operand_b_i = 32'h1; shift_carry_i = 1'b1; flags_i = 4'hF;
        dst_is_pc_i = 1'b1; has_saved_i = 1'b1; saved_flags_i = 4'hA;
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs cleared under reset despite active inputs
        chk("R10", result_o, 32'h0);
        chk("R10", {27'b0, wr_en_o, flags_o}, 32'h0);
        chk("R10", {31'b0, restore_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R9: all opcodes over operand and flag patterns
        for (int op = 0; op < 16; op++)
            for (int ia = 0; ia < 8; ia++)
                for (int ib = 0; ib < 8; ib++)
                    for (int fc = 0; fc < 4; fc++)
                        for (int sc = 0; sc < 2; sc++)
                            run_vec(4'(op), pick(ia), pick(ib), 1'b1,
                                    {fc[0] ^ 1'(ia), 1'(ib), 1'(fc >> 1), fc[0]},
                                    1'(sc), 1'b0, 1'(ia + ib), 4'h5);

        // R7 R8: set-flags, destination-is-PC and saved-status combinations
        for (int op = 0; op < 16; op++)
            for (int combo = 0; combo < 8; combo++)
                for (int ia = 2; ia < 5; ia++)
                    run_vec(4'(op), pick(ia), pick(ia + 1), 1'(combo), 4'h6, 1'b1,
                            1'(combo >> 1), 1'(combo >> 2), 4'h9);

        // R11: output holds until the next rising edge
        run_vec(4'h4, 32'h1, 32'h2, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        operand_a_i = 32'h10; operand_b_i = 32'h20;
        #1;
        chk("R11", result_o, 32'h3);
        @(posedge clk);
        #1;
        chk("R11", result_o, 32'h30);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule